// File: doc/BRIEF.md
# Triple-Copy Strap Majority Voter

This block rebuilds a 32-bit strap word from a byte-wide one-time-programmable array that keeps three redundant copies of it. One pulse on the start input launches a fetch. The block walks the first twelve bytes of the array through a read port with a one-cycle latency and packs every four consecutive bytes into one little-endian copy. It then forms the bitwise two-of-three majority of the three copies.

The result is exposed as a read-only register value with a valid flag. Software and other logic can only observe it; the voter has no write path. The valid flag drops as soon as a fetch is accepted and rises again in the cycle the new vote lands. A start pulse that arrives during a fetch is dropped, so a long read sequence cannot be restarted halfway through.

Top module: `strap_majority_voter`

## Requirements
- R1: While reset is high, and in the first cycle after it, `strap_o` is 0, `strap_vld_o` is 0 and `rd_en_o` is 0. This holds also when reset arrives in the middle of a fetch.
- R2: A start sampled while idle makes the block assert `rd_en_o` in the next cycle with `rd_addr_o` = BASE_ADDR (0 by default). It then steps the address up by one every cycle until BASE_ADDR+11, which is exactly 12 reads with no gaps.
- R3: `rd_data_i` is taken one cycle after the cycle in which its address was driven with `rd_en_o` high.
- R4: Copy n (n = 0, 1, 2) is bytes 4n..4n+3 of the fetched sequence. Byte 4n is the least significant byte, bits 7:0, and byte 4n+3 is bits 31:24.
- R5: Each bit of `strap_o` is (a AND b) OR (a AND c) OR (b AND c) of that bit in copies 0, 1 and 2.
- R6: `strap_vld_o` is 0 from the cycle after an accepted start until the new result is ready. It rises 14 cycles after the clock edge that sampled the start. From then on `strap_o` holds steady with `strap_vld_o` high until the next accepted start.
- R7: A start that arrives while a fetch is in progress is ignored. No extra reads are issued, the address sequence is not restarted, and the result still arrives 14 cycles after the original start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to fetch and vote; sampled on the rising edge |
| rd_en_o | output | 1 | Array read strobe |
| rd_addr_o | output | ADDR_W | Array byte address |
| rd_data_i | input | 8 | Array read data, one cycle after the address |
| strap_o | output | 8*WORD_BYTES | Majority-voted strap value |
| strap_vld_o | output | 1 | High while `strap_o` holds a completed vote |

## Verification
Counting from the edge that samples a start, the first address is due after that same edge. The last byte is captured 13 edges later and the vote and valid flag after edge 14. The bench drives inputs on falling edges and samples on falling edges. It checks that valid is still low after edge 13 and high with the expected word after edge 14. The read order is checked on every read strobe as it happens, and a stray start is placed mid-fetch to confirm that none of these due cycles move.

// File: rtl/strap_pkg.sv
package strap_pkg;

    // Number of redundant copies; the vote function below is 2-of-3.
    localparam int COPIES = 3;
    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] fbyte_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;

    // Read beat returning from the array one cycle after its address.
    typedef struct packed {
        logic live;
        logic last;
    } beat_t;

    function automatic logic vote2of3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/strap_fetch_seq.sv
module strap_fetch_seq
    import strap_pkg::*;
#(
    parameter int TOTAL     = 12,
    parameter int ADDR_W    = 10,
    parameter int BASE_ADDR = 0,
    parameter int IDX_W     = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_i,
    input  logic              done_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              busy_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

    seq_state_e       state_q;
    logic [IDX_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (go_i) begin
                        state_q <= SEQ_ISSUE;
                        cnt_q   <= '0;
                    end
                end
                SEQ_ISSUE: begin
                    if (cnt_q == LAST_IDX) begin
                        state_q <= SEQ_WAIT;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SEQ_WAIT: begin
                    if (done_i) begin
                        state_q <= SEQ_IDLE;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign rd_en_o   = (state_q == SEQ_ISSUE);
    assign rd_addr_o = ADDR_W'(BASE_ADDR) + ADDR_W'(cnt_q);
    assign idx_o     = cnt_q;
    assign busy_o    = (state_q != SEQ_IDLE);

    AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (rst)
        rd_en_o && $past(rd_en_o) |-> rd_addr_o == ADDR_W'($past(rd_addr_o) + ADDR_W'(1))); // R2

endmodule

// File: rtl/strap_word_asm.sv
module strap_word_asm
    import strap_pkg::*;
#(
    parameter int TOTAL = 12,
    parameter int IDX_W = $clog2(TOTAL)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         rd_en_i,
    input  logic [IDX_W-1:0]             idx_i,
    input  fbyte_t                       rd_data_i,
    output logic [TOTAL-1:0][BYTE_W-1:0] bytes_o,
    output logic                         done_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

    beat_t            beat_q;
    logic [IDX_W-1:0] pidx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
            pidx_q <= '0;
            done_o <= 1'b0;
        end else begin
            beat_q.live <= rd_en_i;
            beat_q.last <= rd_en_i && (idx_i == LAST_IDX);
            pidx_q      <= idx_i;
            done_o      <= beat_q.live && beat_q.last;
        end
    end

    for (genvar k = 0; k < TOTAL; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                bytes_o[k] <= '0;
            end else if (beat_q.live && pidx_q == IDX_W'(k)) begin
                bytes_o[k] <= rd_data_i;
            end
        end
    end

    AST_DONE_ONCE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R3

endmodule

// File: rtl/strap_vote.sv
module strap_vote
    import strap_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] cp_a_i,
    input  logic [WIDTH-1:0] cp_b_i,
    input  logic [WIDTH-1:0] cp_c_i,
    output logic [WIDTH-1:0] strap_o,
    output logic             vld_o
);

    logic [WIDTH-1:0] maj;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign maj[b] = vote2of3(cp_a_i[b], cp_b_i[b], cp_c_i[b]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strap_o <= '0;
            vld_o   <= 1'b0;
        end else if (load_i) begin
            strap_o <= maj;
            vld_o   <= 1'b1;
        end else if (clr_i) begin
            vld_o   <= 1'b0;
        end
    end

    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (rst)
        vld_o && $past(vld_o) |-> $stable(strap_o)); // R6

endmodule

// File: rtl/strap_majority_voter.sv
module strap_majority_voter
    import strap_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    parameter int ADDR_W     = 10,
    parameter int BASE_ADDR  = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    output logic                    rd_en_o,
    output logic [ADDR_W-1:0]       rd_addr_o,
    input  logic [BYTE_W-1:0]       rd_data_i,
    output logic [WORD_BYTES*8-1:0] strap_o,
    output logic                    strap_vld_o
);

    localparam int STRAP_W = WORD_BYTES * BYTE_W;
    localparam int TOTAL   = COPIES * WORD_BYTES;
    localparam int IDX_W   = $clog2(TOTAL);

    logic                         busy;
    logic                         go;
    logic                         asm_done;
    logic [IDX_W-1:0]             issue_idx;
    logic [TOTAL-1:0][BYTE_W-1:0] fetched;
    logic [COPIES-1:0][STRAP_W-1:0] copies;

    assign go     = start_i && !busy;
    assign copies = fetched;

    strap_fetch_seq #(
        .TOTAL     (TOTAL),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .IDX_W     (IDX_W)
    ) i_seq (
        .clk       (clk),
        .rst       (rst),
        .go_i      (go),
        .done_i    (asm_done),
        .rd_en_o   (rd_en_o),
        .rd_addr_o (rd_addr_o),
        .idx_o     (issue_idx),
        .busy_o    (busy)
    );

    strap_word_asm #(
        .TOTAL     (TOTAL),
        .IDX_W     (IDX_W)
    ) i_asm (
        .clk       (clk),
        .rst       (rst),
        .rd_en_i   (rd_en_o),
        .idx_i     (issue_idx),
        .rd_data_i (rd_data_i),
        .bytes_o   (fetched),
        .done_o    (asm_done)
    );

    strap_vote #(
        .WIDTH     (STRAP_W)
    ) i_vote (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (go),
        .load_i    (asm_done),
        .cp_a_i    (copies[0]),
        .cp_b_i    (copies[1]),
        .cp_c_i    (copies[2]),
        .strap_o   (strap_o),
        .vld_o     (strap_vld_o)
    );

    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (strap_o == '0) && !strap_vld_o && !rd_en_o); // R1

    AST_QUIET_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !strap_vld_o); // R6

    AST_VLD_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst)
        $rose(strap_vld_o) |-> $past(asm_done)); // R6

    AST_LAST_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
        asm_done |-> busy && !rd_en_o); // R3

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        busy && rd_en_o && start_i |=> !(rd_en_o && rd_addr_o == ADDR_W'(BASE_ADDR))); // R7

endmodule

// File: tb/test_strap_majority_voter.sv
module test_strap_majority_voter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        rd_en;
    logic [9:0]  rd_addr;
    logic [7:0]  rd_data = 8'h00;
    logic [31:0] strap;
    logic        strap_vld;

    logic [7:0]  fmem [16];
    logic        rd_clr = 1'b0;
    int          rd_cnt = 0;
    logic        order_bad = 1'b0;

    int n_cmp  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    strap_majority_voter i_strap_majority_voter (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .rd_en_o     (rd_en),
        .rd_addr_o   (rd_addr),
        .rd_data_i   (rd_data),
        .strap_o     (strap),
        .strap_vld_o (strap_vld)
    );

    // Array model: one-cycle read latency, plus an order monitor.
    always @(posedge clk) begin
        if (rd_en) rd_data <= fmem[rd_addr[3:0]];
        if (rd_clr) begin
            rd_cnt    <= 0;
            order_bad <= 1'b0;
        end else if (rd_en) begin
            if (rd_addr != 10'(rd_cnt)) order_bad <= 1'b1;
            rd_cnt <= rd_cnt + 1;
        end
    end

    // {copy0, copy1, copy2, expected}
    localparam logic [127:0] VEC [6] = '{
        {32'h12345678, 32'h12345678, 32'h12345678, 32'h12345678},
        {32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'h00000000},
        {32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFFF},
        {32'hF0F0F0F0, 32'hCCCCCCCC, 32'hAAAAAAAA, 32'hE8E8E8E8},
        {32'hA5A50001, 32'hA5A50001, 32'h5A5AFFFE, 32'hA5A50001},
        {32'h11223344, 32'hDEADBEEF, 32'h11223344, 32'h11223344}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_mem(input logic [31:0] c0, input logic [31:0] c1, input logic [31:0] c2);
        for (int k = 0; k < 4; k++) begin
            fmem[k]     = c0[8*k +: 8];
            fmem[4 + k] = c1[8*k +: 8];
            fmem[8 + k] = c2[8*k +: 8];
        end
        for (int k = 12; k < 16; k++) fmem[k] = 8'h5C;
    endtask

    task automatic run_case(input logic [127:0] v, input bit stray);
        load_mem(v[127:96], v[95:64], v[63:32]);
        @(negedge clk);
        start_i = 1'b1;
        rd_clr  = 1'b1;
        @(negedge clk);                      // after the start edge
        start_i = 1'b0;
        rd_clr  = 1'b0;
        chk("R2 first read", {21'd0, rd_en, rd_addr}, {21'd0, 1'b1, 10'd0});
        chk("R6 valid low", {31'd0, strap_vld}, 32'd0);
        if (stray) begin
            repeat (4) @(negedge clk);
            start_i = 1'b1;                  // R7: arrives mid-fetch
            @(negedge clk);
            start_i = 1'b0;
            repeat (8) @(negedge clk);
        end else begin
            repeat (13) @(negedge clk);
        end
        chk("R6 valid low after edge 13", {31'd0, strap_vld}, 32'd0);
        @(negedge clk);
        chk("R6 valid high after edge 14", {31'd0, strap_vld}, 32'd1);
        chk("R5 R4 voted word", strap, v[31:0]);
        chk("R2 R7 read count", 32'(rd_cnt), 32'd12);
        chk("R2 ascending order", {31'd0, order_bad}, 32'd0);
        repeat (2) @(negedge clk);
        chk("R6 result held", strap, v[31:0]);
        chk("R6 valid held", {31'd0, strap_vld}, 32'd1);
    endtask

    initial begin
        load_mem(32'h0, 32'h0, 32'h0);
        repeat (3) @(negedge clk);
        chk("R1 reset strap", strap, 32'd0);
        chk("R1 reset valid", {31'd0, strap_vld}, 32'd0);
        chk("R1 reset read strobe", {31'd0, rd_en}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle without start", {30'd0, rd_en, strap_vld}, 32'd0);

        for (int i = 0; i < 6; i++) run_case(VEC[i], (i % 2) == 1);

        // R1: reset after a completed vote clears the result
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset clears strap", strap, 32'd0);
        chk("R1 reset clears valid", {31'd0, strap_vld}, 32'd0);

        // R1: reset in the middle of a fetch
        load_mem(32'h0F0F0F0F, 32'h0F0F0F0F, 32'h0F0F0F0F);
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid-fetch reset read strobe", {31'd0, rd_en}, 32'd0);
        chk("R1 mid-fetch reset valid", {31'd0, strap_vld}, 32'd0);
        repeat (16) @(negedge clk);
        chk("R1 no result after abort", {31'd0, strap_vld}, 32'd0);
        chk("R1 strap stays zero", strap, 32'd0);

        // R3 R4: fresh fetch after abort uses new bytes
        run_case({32'h0F0F0F0F, 32'h0F0F0F0F, 32'h00FF00FF, 32'h0F0F0F0F}, 1'b0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

endmodule